// File: doc/BRIEF.md
# Reference Clock Divider Chain

This block turns a single fast reference clock into a family of slower timing strobes for a mixed-signal radio front end. Every output lives in the reference clock domain: the chain never makes a new clock, it produces enables. Downstream logic qualifies its flops with these enables.

There are two parallel programmable paths and one cascade. One 12-bit divider gives the frequency-synthesizer comparison tick. A 6-bit divider, followed by a toggle stage, gives the switched-capacitor filter clock as a 50% duty level plus a once-per-period strobe. A second 6-bit divider gives the 16x bit-recovery strobe. That strobe is divided by a fixed 16 to get the encoder bit strobe. The encoder strobe is then divided by a fixed 32, and the result steps a 4-bit delay counter that raises a done flag when an idle-detection delay has elapsed.

Divider values are plain register inputs and may change at any time. A change is applied only at the end of the current period.

Top module: `refclk_div_chain`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `pll_tick_o`, `flt_tick_o`, `flt_level_o`, `rec_tick_o`, `enc_tick_o` and `idle_done_o` are all 0.
- R2: With `pll_div_i` = N ≥ 1 held, `pll_tick_o` is a one-cycle pulse repeating every N reference cycles. For N = 1 it is high every cycle.
- R3: With `flt_div_i` = N ≥ 1 held, `flt_level_o` toggles every N cycles, so it is high for N of every 2N cycles. `flt_tick_o` pulses once every 2N cycles, in the cycle just before `flt_level_o` goes from 0 to 1.
- R4: With `rec_div_i` = N ≥ 1 held, `rec_tick_o` pulses once every N cycles.
- R5: `enc_tick_o` fires only in a cycle where `rec_tick_o` is also high, on every 16th `rec_tick_o` pulse.
- R6: A divider value of 0 stops its output. After the terminal count that picks up the 0, no further pulses appear until a nonzero value is written. Once a nonzero value N is written, pulses resume within N+1 cycles.
- R7: A new divider value written part way through a period does not change that period. The period in progress ends with the old length, and the following periods use the new one.
- R8: A one-cycle `idle_start_i` with `idle_div_i` = D ≥ 1 raises `idle_done_o` in the cycle after the (32·D)-th `enc_tick_o` pulse counted from the cycle after the start. With D = 0, `idle_done_o` rises in the cycle after the start.
- R9: `idle_done_o` stays high until the next `idle_start_i`. A start with D ≥ 1 clears it in the following cycle and restarts the delay from zero, including the divide-by-32 prescaler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pll_div_i | input | 12 | Synthesizer reference divide value (0 = stop) |
| flt_div_i | input | 6 | Filter clock pre-divide value (0 = stop) |
| rec_div_i | input | 6 | 16x recovery strobe divide value (0 = stop) |
| idle_div_i | input | 4 | Idle delay length in prescaled steps |
| idle_start_i | input | 1 | Synchronous start/restart of the idle delay |
| pll_tick_o | output | 1 | Synthesizer reference strobe |
| flt_tick_o | output | 1 | Filter clock strobe, once per filter period |
| flt_level_o | output | 1 | Filter clock 50% duty level |
| rec_tick_o | output | 1 | 16x bit-recovery strobe |
| enc_tick_o | output | 1 | Encoder bit strobe |
| idle_done_o | output | 1 | Idle delay expired |

## Verification
The bench measures gaps between strobes, not absolute arrival times. An off-by-one terminal count therefore shows up directly as a period of N±1.

It rewrites a divider value mid-period. A design that reloads immediately would show a truncated or stretched period.

It writes zero and then a nonzero value again. A design that divides by 2^W, or never recovers, would show stray or missing pulses.

The idle timer is checked by counting encoder strobes up to the exact cycle the done flag rises. This exposes a prescaler that is not cleared on start, a counter that is off by one step, and a done flag that fails to stick or fails to clear on restart.

// File: rtl/refclk_div_pkg.sv
package refclk_div_pkg;
  localparam int unsigned PLL_W_DEF   = 12;
  localparam int unsigned FLT_W_DEF   = 6;
  localparam int unsigned REC_W_DEF   = 6;
  localparam int unsigned IDLE_W_DEF  = 4;
  localparam int unsigned ENC_RATIO   = 16;
  localparam int unsigned IDLE_PRESC  = 32;

  function automatic int unsigned cnt_width(input int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/rcd_prog_div.sv
module rcd_prog_div #(
  parameter int unsigned W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] div_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic [W-1:0] lim_q, lim_d;
  logic         tc;

  // terminal count of the period that is running
  assign tc     = (lim_q != '0) && (cnt_q == lim_q - W'(1));
  assign tick_o = tc;

  always_comb begin
    cnt_d = cnt_q;
    lim_d = lim_q;
    if (lim_q == '0) begin
      // stopped: sample the register every cycle
      lim_d = div_i;
      cnt_d = '0;
    end else if (tc) begin
      // a new value is only picked up at a period boundary
      lim_d = div_i;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lim_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      lim_q <= lim_d;
    end
  end
endmodule

// File: rtl/rcd_fixed_div.sv
module rcd_fixed_div #(
  parameter int unsigned N = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = refclk_div_pkg::cnt_width(N);
  localparam logic [CW-1:0] LAST = CW'(N - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          wrap;

  assign wrap   = en_i && !clr_i && (cnt_q == LAST);
  assign tick_o = wrap;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (en_i) begin
      cnt_d = wrap ? '0 : cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/rcd_idle_timer.sv
module rcd_idle_timer #(
  parameter int unsigned W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [W-1:0] load_i,
  input  logic         step_i,
  output logic         done_o
);
  logic [W-1:0] rem_q, rem_d;
  logic         run_q, run_d;
  logic         done_q, done_d;

  always_comb begin
    rem_d  = rem_q;
    run_d  = run_q;
    done_d = done_q;
    if (start_i) begin
      rem_d  = load_i;
      run_d  = (load_i != '0);
      done_d = (load_i == '0);
    end else if (run_q && step_i) begin
      if (rem_q == W'(1)) begin
        rem_d  = '0;
        run_d  = 1'b0;
        done_d = 1'b1;
      end else begin
        rem_d = rem_q - W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      run_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      run_q  <= run_d;
      done_q <= done_d;
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/refclk_div_chain.sv
module refclk_div_chain #(
  parameter int unsigned PLL_W  = refclk_div_pkg::PLL_W_DEF,
  parameter int unsigned FLT_W  = refclk_div_pkg::FLT_W_DEF,
  parameter int unsigned REC_W  = refclk_div_pkg::REC_W_DEF,
  parameter int unsigned IDLE_W = refclk_div_pkg::IDLE_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PLL_W-1:0]  pll_div_i,
  input  logic [FLT_W-1:0]  flt_div_i,
  input  logic [REC_W-1:0]  rec_div_i,
  input  logic [IDLE_W-1:0] idle_div_i,
  input  logic              idle_start_i,
  output logic              pll_tick_o,
  output logic              flt_tick_o,
  output logic              flt_level_o,
  output logic              rec_tick_o,
  output logic              enc_tick_o,
  output logic              idle_done_o
);
  logic flt_pre_tick;
  logic flt_lvl_q, flt_lvl_d;
  logic idle_step;

  rcd_prog_div #(.W(PLL_W)) i_pll_div (
    .clk_i (clk_i), .rst_ni(rst_ni), .div_i(pll_div_i), .tick_o(pll_tick_o)
  );

  rcd_prog_div #(.W(FLT_W)) i_flt_div (
    .clk_i (clk_i), .rst_ni(rst_ni), .div_i(flt_div_i), .tick_o(flt_pre_tick)
  );

  // divide-by-two toggle stage of the filter path
  always_comb begin
    flt_lvl_d = flt_lvl_q;
    if (flt_pre_tick) flt_lvl_d = ~flt_lvl_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flt_lvl_q <= 1'b0;
    else         flt_lvl_q <= flt_lvl_d;
  end

  assign flt_level_o = flt_lvl_q;
  assign flt_tick_o  = flt_pre_tick && !flt_lvl_q;

  rcd_prog_div #(.W(REC_W)) i_rec_div (
    .clk_i (clk_i), .rst_ni(rst_ni), .div_i(rec_div_i), .tick_o(rec_tick_o)
  );

  rcd_fixed_div #(.N(refclk_div_pkg::ENC_RATIO)) i_enc_div (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(1'b0),
    .en_i  (rec_tick_o), .tick_o(enc_tick_o)
  );

  rcd_fixed_div #(.N(refclk_div_pkg::IDLE_PRESC)) i_idle_pre (
    .clk_i (clk_i), .rst_ni(rst_ni), .clr_i(idle_start_i),
    .en_i  (enc_tick_o), .tick_o(idle_step)
  );

  rcd_idle_timer #(.W(IDLE_W)) i_idle_tmr (
    .clk_i  (clk_i), .rst_ni(rst_ni), .start_i(idle_start_i),
    .load_i (idle_div_i), .step_i(idle_step), .done_o(idle_done_o)
  );
endmodule

// File: rtl/refclk_div_chain_chk.sv
module refclk_div_chain_chk #(
  parameter int unsigned PLL_W  = 12,
  parameter int unsigned FLT_W  = 6,
  parameter int unsigned REC_W  = 6,
  parameter int unsigned IDLE_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [PLL_W-1:0]  pll_div_i,
  input logic [FLT_W-1:0]  flt_div_i,
  input logic [REC_W-1:0]  rec_div_i,
  input logic [IDLE_W-1:0] idle_div_i,
  input logic              idle_start_i,
  input logic              pll_tick_o,
  input logic              flt_tick_o,
  input logic              flt_level_o,
  input logic              rec_tick_o,
  input logic              enc_tick_o,
  input logic              idle_done_o
);
  p_enc_in_rec_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    enc_tick_o |-> rec_tick_o);

  p_flt_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flt_tick_o |=> flt_level_o);

  p_pll_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pll_tick_o && pll_div_i > PLL_W'(1)) |=> !pll_tick_o);

  p_done_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_done_o && !idle_start_i) |=> idle_done_o);

  p_start_clears_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_start_i && idle_div_i != '0) |=> !idle_done_o);

  p_zero_delay_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_start_i && idle_div_i == '0) |=> idle_done_o);
endmodule

bind refclk_div_chain refclk_div_chain_chk #(
  .PLL_W(PLL_W), .FLT_W(FLT_W), .REC_W(REC_W), .IDLE_W(IDLE_W)
) i_chk (.*);

// File: tb/test_refclk_div_chain.sv
module test_refclk_div_chain;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [11:0] pll_div_i;
  logic [5:0]  flt_div_i;
  logic [5:0]  rec_div_i;
  logic [3:0]  idle_div_i;
  logic        idle_start_i;
  logic        pll_tick_o, flt_tick_o, flt_level_o, rec_tick_o, enc_tick_o, idle_done_o;

  int n_cmp  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk_i = ~clk_i;

  refclk_div_chain i_refclk_div_chain (.*);

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic sig(input int k);
    case (k)
      0: return pll_tick_o;
      1: return flt_tick_o;
      2: return rec_tick_o;
      default: return enc_tick_o;
    endcase
  endfunction

  task automatic wait_tick(input int k);
    do @(negedge clk_i); while (!sig(k));
  endtask

  // from a negedge at which signal k was seen high, count cycles to the next
  task automatic next_gap(input int k, output int gap);
    gap = 0;
    do begin @(negedge clk_i); gap++; end while (!sig(k));
  endtask

  task automatic t_reset;
    rst_ni = 1'b0; pll_div_i = 12'd5; flt_div_i = 6'd3; rec_div_i = 6'd2;
    idle_div_i = 4'd0; idle_start_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R1 rst outs", {pll_tick_o, flt_tick_o, flt_level_o, rec_tick_o,
                          enc_tick_o, idle_done_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1 first cycle", {pll_tick_o, flt_tick_o, flt_level_o, rec_tick_o,
                             enc_tick_o, idle_done_o}, 0);
  endtask

  task automatic t_pll_period;
    int g;
    wait_tick(0);
    for (int i = 0; i < 3; i++) begin next_gap(0, g); check("R2 pll period 5", g, 5); end
    pll_div_i = 12'd1;
    wait_tick(0); wait_tick(0);
    for (int i = 0; i < 3; i++) begin next_gap(0, g); check("R2 pll period 1", g, 1); end
    pll_div_i = 12'd5;
  endtask

  task automatic t_change;
    int g;
    wait_tick(0); wait_tick(0);
    repeat (2) @(negedge clk_i);
    pll_div_i = 12'd7;
    g = 2;
    do begin @(negedge clk_i); g++; end while (!pll_tick_o);
    check("R7 old period kept", g, 5);
    next_gap(0, g); check("R7 new period", g, 7);
    next_gap(0, g); check("R7 new period again", g, 7);
  endtask

  task automatic t_zero;
    int cnt = 0;
    int g;
    wait_tick(0);
    pll_div_i = 12'd0;
    repeat (40) begin @(negedge clk_i); if (pll_tick_o) cnt++; end
    check("R6 zero stops pll", cnt, 0);
    pll_div_i = 12'd4;
    g = 0;
    do begin @(negedge clk_i); g++; end while (!pll_tick_o && g < 20);
    check("R6 resume within N+1", (g <= 5) ? 1 : 0, 1);
    next_gap(0, g); check("R6 resumed period", g, 4);
  endtask

  task automatic t_flt;
    int g, hi;
    wait_tick(1);
    for (int i = 0; i < 2; i++) begin next_gap(1, g); check("R3 flt tick period", g, 6); end
    hi = 0;
    for (int i = 0; i < 6; i++) begin @(negedge clk_i); if (flt_level_o) hi++; end
    check("R3 flt level duty", hi, 3);
  endtask

  task automatic t_rec_enc;
    int g, nrec;
    wait_tick(2);
    for (int i = 0; i < 2; i++) begin next_gap(2, g); check("R4 rec period", g, 2); end
    wait_tick(3);
    nrec = 0;
    do begin
      @(negedge clk_i);
      if (rec_tick_o) nrec++;
      if (enc_tick_o && !rec_tick_o) check("R5 enc without rec", 1, 0);
    end while (!enc_tick_o);
    check("R5 rec per enc", nrec, 16);
    next_gap(3, g); check("R5 enc period", g, 32);
  endtask

  task automatic do_start(input logic [3:0] d);
    @(negedge clk_i);
    idle_div_i = d; idle_start_i = 1'b1;
    @(negedge clk_i);
    idle_start_i = 1'b0;
  endtask

  // call right after do_start: count enc strobes until done is seen
  task automatic count_to_done(output int nenc);
    nenc = 0;
    while (!idle_done_o && nenc < 200) begin
      if (enc_tick_o) nenc++;
      @(negedge clk_i);
    end
  endtask

  task automatic t_idle;
    int nenc;
    repeat (7) @(negedge clk_i);
    do_start(4'd2);
    count_to_done(nenc);
    check("R8 enc strobes to done D=2", nenc, 64);
    repeat (100) @(negedge clk_i);
    check("R9 done sticks", idle_done_o, 1);
    do_start(4'd1);
    check("R9 restart clears", idle_done_o, 0);
    repeat (13) @(negedge clk_i);
    do_start(4'd1);
    count_to_done(nenc);
    check("R9 restart from zero", nenc, 32);
    do_start(4'd0);
    check("R8 zero delay", idle_done_o, 1);
  endtask

  initial begin
    t_reset();
    t_pll_period();
    t_change();
    t_zero();
    t_flt();
    t_rec_enc();
    t_idle();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      finished = 1'b1;
      n_cmp++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
      $finish;
    end
  end
endmodule